// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Gate Sequencer

This block is the clocked control core of one half-bridge channel. It turns a pulse-width command into two gate enables, one for the high-side switch and one for the low-side switch, and it never lets both be on together. The command arrives as two comparator flags: one says the input is above the upper threshold, the other says it is below the lower threshold. When neither flag is set, the input is in the middle window. Between the two thresholds the last decided level is kept, which gives the command hysteresis.

Dead time is not a fixed count. It follows feedback from the power stage. The upper switch turns on only once a comparator reports that the lower gate has fallen below its turn-off level. The lower switch turns on once the switch node is reported low. If the switch node does not go low, the lower switch is forced on after a bounded wait so that the bootstrap supply gets recharged. If the switch node stays high for too long while the lower switch conducts, the lower switch is turned off and both gates stay off until the next rising command, so the lower switch behaves like a diode. A middle-window command held past a holdoff time shuts both gates off. Both gates are also held off while the supply-good flag is low. Every comparator flag passes through a synchronizer, and all time limits are parameters counted in clock cycles.

Top module: `halfbridge_gate_seq`

## Requirements
- R1: gate_hi_o and gate_lo_o are never 1 in the same cycle, including during and after reset.
- R2: When the command rises, the lower enable drops first. The upper enable rises only after lg_low_i has been seen high, and it stays 0 for as long as lg_low_i stays 0.
- R3: When the command falls, the upper enable drops first. The lower enable rises within a few cycles after sw_low_i is seen high, even when the refresh wait has not expired.
- R4: If sw_low_i stays 0 after the upper enable drops, the lower enable rises exactly REFRESH_CYC cycles after the upper enable fell. The cycles in which both enables are 0 number REFRESH_CYC.
- R5: If sw_low_i is 0 for DIODE_CYC consecutive cycles while the lower enable is on, the lower enable drops. Both enables then stay 0 while the command stays low, and the next rising command restarts the normal sequence.
- R6: Any cycle in which sw_low_i is seen high restarts the DIODE_CYC count, so a single high pulse keeps the lower enable on past DIODE_CYC cycles measured from its rise.
- R7: A command in the middle window (pwm_above_i=0 and pwm_below_i=0) for HOLDOFF_CYC consecutive cycles forces both enables to 0. When the command leaves the window, the new level starts the normal sequence at once.
- R8: A middle-window stay shorter than HOLDOFF_CYC has no effect on the enables, and the last decided level is kept (hysteresis).
- R9: While supply_ok_i is 0, both enables are 0 whatever the command. After supply_ok_i rises, the present command level starts the normal sequence.
- R10: While rst is 1, both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_above_i | input | 1 | Command above the upper threshold (asynchronous, takes priority) |
| pwm_below_i | input | 1 | Command below the lower threshold (asynchronous) |
| supply_ok_i | input | 1 | Supply-good flag with hysteresis (asynchronous) |
| lg_low_i | input | 1 | Lower gate is below its turn-off level (asynchronous) |
| sw_low_i | input | 1 | Switch node is below its low threshold (asynchronous) |
| gate_hi_o | output | 1 | High-side gate enable (registered) |
| gate_lo_o | output | 1 | Low-side gate enable (registered) |

## Verification
The hardest condition to reach is a diode-emulation turn-off that comes after a forced bootstrap refresh. The switch node has to be kept high through the whole refresh wait and then through the whole conduction window. The stimulus therefore holds sw_low_i at 0 across one falling command. It then counts the exact number of both-off cycles and lower-on cycles at the outputs. The count-restart case is reached with a single one-cycle-wide low pulse on the switch node placed mid-window, followed by a second long high stretch.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;
  typedef enum logic [2:0] {
    SQ_HOLD    = 3'd0,
    SQ_HI_WAIT = 3'd1,
    SQ_HI_ON   = 3'd2,
    SQ_LO_WAIT = 3'd3,
    SQ_LO_ON   = 3'd4,
    SQ_DIODE   = 3'd5
  } seq_state_t;
endpackage

// File: rtl/gsq_sync.sv
module gsq_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gsq_dwell_timer.sv
module gsq_dwell_timer #(
  parameter int LIMIT = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic cond_i,
  output logic done_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !cond_i) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = cond_i && (cnt_q == LAST);

  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R4
  AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (rst)
    !cond_i |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/gsq_seq_fsm.sv
module gsq_seq_fsm
  import gate_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic above_s,
  input  logic below_s,
  input  logic supply_s,
  input  logic lg_low_s,
  input  logic sw_low_s,
  input  logic refresh_done,
  input  logic diode_done,
  input  logic mid_done,
  output logic refresh_run,
  output logic diode_run,
  output logic hi_q,
  output logic lo_q
);
  seq_state_t st_q, st_d;
  logic cmd_hi, cmd_lo;

  assign cmd_hi = above_s;
  assign cmd_lo = below_s && !above_s;

  always_comb begin
    st_d = st_q;
    if (!supply_s || mid_done) begin
      st_d = SQ_HOLD;
    end else begin
      unique case (st_q)
        SQ_HOLD: begin
          if (cmd_hi) st_d = SQ_HI_WAIT;
          else if (cmd_lo) st_d = SQ_LO_WAIT;
        end
        SQ_HI_WAIT: begin
          if (cmd_lo) st_d = SQ_LO_WAIT;
          else if (lg_low_s) st_d = SQ_HI_ON;
        end
        SQ_HI_ON: begin
          if (cmd_lo) st_d = SQ_LO_WAIT;
        end
        SQ_LO_WAIT: begin
          if (cmd_hi) st_d = SQ_HI_WAIT;
          else if (sw_low_s || refresh_done) st_d = SQ_LO_ON;
        end
        SQ_LO_ON: begin
          if (cmd_hi) st_d = SQ_HI_WAIT;
          else if (diode_done) st_d = SQ_DIODE;
        end
        SQ_DIODE: begin
          if (cmd_hi) st_d = SQ_HI_WAIT;
        end
        default: st_d = SQ_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= SQ_HOLD;
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      st_q <= st_d;
      hi_q <= (st_d == SQ_HI_ON);
      lo_q <= (st_d == SQ_LO_ON);
    end
  end

  assign refresh_run = (st_q == SQ_LO_WAIT);
  assign diode_run   = (st_q == SQ_LO_ON) && !sw_low_s;

  AST_GATES_EXCLUSIVE: assert property (@(posedge clk)
    !(hi_q && lo_q)); // R1
  AST_HI_NEEDS_LG_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_q) |-> ($past(lg_low_s) && !$past(lo_q))); // R2
  AST_LO_AFTER_HI_OFF: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_q) |-> !$past(hi_q)); // R3
  AST_SUPPLY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !supply_s |=> (!hi_q && !lo_q)); // R9
  AST_MID_SHUTDOWN: assert property (@(posedge clk) disable iff (rst)
    mid_done |=> (!hi_q && !lo_q)); // R7
  AST_DIODE_OFF: assert property (@(posedge clk) disable iff (rst)
    (diode_done && supply_s && !cmd_hi) |=> !lo_q); // R5
endmodule

// File: rtl/halfbridge_gate_seq.sv
module halfbridge_gate_seq #(
  parameter int REFRESH_CYC = 50,
  parameter int DIODE_CYC   = 400,
  parameter int HOLDOFF_CYC = 46,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwm_above_i,
  input  logic pwm_below_i,
  input  logic supply_ok_i,
  input  logic lg_low_i,
  input  logic sw_low_i,
  output logic gate_hi_o,
  output logic gate_lo_o
);
  localparam int NFLAG = 5;

  logic [NFLAG-1:0] raw_flags, syn_flags;
  logic above_s, below_s, supply_s, lg_low_s, sw_low_s;
  logic mid_s, refresh_run, diode_run;
  logic refresh_done, diode_done, mid_done;

  assign raw_flags = {sw_low_i, lg_low_i, supply_ok_i, pwm_below_i, pwm_above_i};

  gsq_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_flags), .q_o(syn_flags)
  );

  assign above_s  = syn_flags[0];
  assign below_s  = syn_flags[1];
  assign supply_s = syn_flags[2];
  assign lg_low_s = syn_flags[3];
  assign sw_low_s = syn_flags[4];
  assign mid_s    = !above_s && !below_s;

  gsq_dwell_timer #(.LIMIT(REFRESH_CYC)) u_refresh_tmr (
    .clk(clk), .rst(rst), .cond_i(refresh_run), .done_o(refresh_done)
  );
  gsq_dwell_timer #(.LIMIT(DIODE_CYC)) u_diode_tmr (
    .clk(clk), .rst(rst), .cond_i(diode_run), .done_o(diode_done)
  );
  gsq_dwell_timer #(.LIMIT(HOLDOFF_CYC)) u_mid_tmr (
    .clk(clk), .rst(rst), .cond_i(mid_s), .done_o(mid_done)
  );

  gsq_seq_fsm u_fsm (
    .clk(clk), .rst(rst),
    .above_s(above_s), .below_s(below_s), .supply_s(supply_s),
    .lg_low_s(lg_low_s), .sw_low_s(sw_low_s),
    .refresh_done(refresh_done), .diode_done(diode_done), .mid_done(mid_done),
    .refresh_run(refresh_run), .diode_run(diode_run),
    .hi_q(gate_hi_o), .lo_q(gate_lo_o)
  );

  AST_RESET_OFF: assert property (@(posedge clk)
    $past(rst) |-> (!gate_hi_o && !gate_lo_o)); // R10
endmodule

// File: tb/halfbridge_gate_seq_bench.sv
module halfbridge_gate_seq_bench;
  localparam int REFRESH = 50;
  localparam int DIODE   = 400;
  localparam int HOLDOFF = 46;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic above = 1'b0, below = 1'b0, sup = 1'b0, lgl = 1'b0, swl = 1'b0;
  logic ghi, glo;
  int   n_chk = 0, n_bad = 0, n_overlap = 0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  halfbridge_gate_seq #(.REFRESH_CYC(REFRESH), .DIODE_CYC(DIODE), .HOLDOFF_CYC(HOLDOFF))
  u_halfbridge_gate_seq (
    .clk(clk), .rst(rst), .pwm_above_i(above), .pwm_below_i(below),
    .supply_ok_i(sup), .lg_low_i(lgl), .sw_low_i(swl),
    .gate_hi_o(ghi), .gate_lo_o(glo)
  );

  always @(negedge clk) if (ghi && glo) n_overlap++;

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_pwm(input int lvl); // 1 high, 0 low, 2 mid
    above = (lvl == 1);
    below = (lvl == 0);
  endtask

  task automatic t_reset;
    tick(6);
    chk("R10 hi in reset", ghi, 0);
    chk("R10 lo in reset", glo, 0);
    rst = 1'b0;
  endtask

  task automatic t_supply;
    set_pwm(1); lgl = 1'b1; swl = 1'b0;
    tick(20);
    chk("R9 hi with supply low", ghi, 0);
    chk("R9 lo with supply low", glo, 0);
    sup = 1'b1;
    tick(6);
    chk("R9 hi after supply up", ghi, 1);
    sup = 1'b0;
    tick(5);
    chk("R9 hi after supply drop", ghi, 0);
    sup = 1'b1;
    tick(6);
    chk("R9 hi after supply return", ghi, 1);
  endtask

  task automatic t_falling;
    set_pwm(0);
    tick(4);
    chk("R3 hi off first", ghi, 0);
    tick(10);
    chk("R3 lo waits for switch node", glo, 0);
    swl = 1'b1;
    tick(4);
    chk("R3 lo on after switch node low", glo, 1);
    lgl = 1'b0;
  endtask

  task automatic t_rising;
    set_pwm(1);
    tick(4);
    chk("R2 lo off first", glo, 0);
    tick(20);
    chk("R2 hi held while lg high", ghi, 0);
    lgl = 1'b1;
    tick(4);
    chk("R2 hi on after lg low", ghi, 1);
  endtask

  task automatic t_refresh_diode;
    int n;
    swl = 1'b0;
    set_pwm(0);
    n = 0;
    while (ghi && n < 20) begin n++; tick(1); end
    n = 0;
    while (!glo && n < 200) begin n++; tick(1); end
    chk("R4 refresh gap cycles", n, REFRESH);
    n = 0;
    while (glo && n < 2000) begin n++; tick(1); end
    chk("R5 lower on cycles before diode off", n, DIODE);
    tick(30);
    chk("R5 lo stays off", glo, 0);
    chk("R5 hi stays off", ghi, 0);
    set_pwm(1);
    tick(4);
    chk("R5 rising restarts sequence", ghi, 1);
  endtask

  task automatic t_diode_restart;
    set_pwm(0); swl = 1'b1;
    tick(6);
    chk("R6 lo on", glo, 1);
    swl = 1'b0; tick(300);
    swl = 1'b1; tick(1);
    swl = 1'b0; tick(300);
    chk("R6 lo kept on after restart", glo, 1);
    tick(130);
    chk("R6 lo off after full window", glo, 0);
  endtask

  task automatic t_mid;
    int dropped;
    swl = 1'b0; lgl = 1'b1;
    set_pwm(1);
    tick(6);
    chk("R8 hi on before mid", ghi, 1);
    set_pwm(2);
    dropped = 0;
    for (int i = 0; i < 40; i++) begin tick(1); if (!ghi) dropped = 1; end
    set_pwm(1);
    for (int i = 0; i < 10; i++) begin tick(1); if (!ghi) dropped = 1; end
    chk("R8 short mid no effect", dropped, 0);
    set_pwm(2);
    tick(80);
    chk("R7 hi off in shutdown", ghi, 0);
    chk("R7 lo off in shutdown", glo, 0);
    swl = 1'b1;
    set_pwm(0);
    tick(6);
    chk("R7 exit to low starts lower", glo, 1);
    set_pwm(2);
    tick(80);
    chk("R7 lo off in shutdown", glo, 0);
    set_pwm(1);
    tick(6);
    chk("R7 exit to high starts upper", ghi, 1);
  endtask

  initial begin
    t_reset();
    t_supply();
    t_falling();
    t_rising();
    t_refresh_diode();
    t_diode_restart();
    t_mid();
    chk("R1 overlap samples", n_overlap, 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule